// File: doc/BRIEF.md
# Privilege Mode and Stack Banking Unit

This unit keeps the processor's privilege state, held as one bit of a 16-bit status word: supervisor when the bit is set, user when it is clear. The generic stack-pointer name (address register seven) is redirected to one of two physical pointers according to that bit. The supervisor pointer is selected in supervisor mode and the user pointer in user mode. Every instruction cycle is also tagged as a supervisor or user bus reference.

The unit receives a decoded instruction class with each issued instruction. When a user-mode program issues a restricted class, the unit flags a privilege violation in that same cycle. It blocks every register and mode write of that instruction, and it starts an exception entry on the following cycle. Exception entry is the only path back to supervisor mode. On entry the unit records the previous mode bit and then forces the mode bit to 1. An enable input widens the restricted set to cover status reads, control-register moves and alternate-space moves.

Top module: `priv_stack_unit`

## Requirements
- R1: Synchronous reset, active high, gives the status word 0x2000 (supervisor). It also clears the saved-mode flag and sets both stack pointers to 0.
- R2: The mode bit is bit 13 of the status word. `sup_mode` and `bus_super` both equal that bit in every cycle, so each instruction's bus reference carries the mode it issued in.
- R3: `a7_rdata` shows the supervisor pointer when the mode bit is 1 and the user pointer when it is 0. An `a7_wr_en` write goes to that same pointer only, and the other pointer keeps its value.
- R4: In user mode, an issued instruction of class 1 (halt), 2 (external reset), 3 (whole status write) or 4 (user pointer move) raises `priv_viol` in its issue cycle. None of these classes raises it in supervisor mode.
- R5: Classes 5 (status read), 6 (control-register move) and 7 (alternate-space move) raise `priv_viol` in user mode only when `ext_priv_en` is 1. Class 0 and classes 8 to 15 never raise it.
- R6: A status write with `sr_wr_full`=1 loads all 16 bits in supervisor mode. In user mode the same write raises `priv_viol` and leaves the status word unchanged.
- R7: A status write with `sr_wr_full`=0 updates only bits 7:0, in either mode. A user-mode program can never set the mode bit by any write.
- R8: An instruction that raises `priv_viol` commits nothing. The status word, both stack pointers and the mode stay as they were.
- R9: `exc_taken` is 1 in the cycle after a violation and in any cycle with `exc_entry`=1. At the next edge the old mode bit goes to `saved_s` and the mode bit becomes 1. All instruction writes in an `exc_taken` cycle are discarded, and that cycle raises no violation.
- R10: A supervisor status write that clears bit 13 switches `a7_rdata` to the user pointer from the next cycle. Both pointer values are retained.
- R11: In supervisor mode, `usp_wr_en` writes the user pointer directly and `usp_rdata` always shows it. In user mode `usp_wr_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction issues this cycle |
| instr_class | input | 4 | Decoded instruction class |
| ext_priv_en | input | 1 | Widen the restricted set to classes 5-7 |
| sr_wr_en | input | 1 | Instruction writes the status word |
| sr_wr_full | input | 1 | 1: whole status word, 0: low byte only |
| sr_wr_data | input | 16 | Status write data |
| exc_entry | input | 1 | External exception entry request |
| a7_wr_en | input | 1 | Write to the mode-selected stack pointer |
| a7_wr_data | input | ADDR_W | Stack pointer write data |
| usp_wr_en | input | 1 | Direct user pointer write (supervisor only) |
| usp_wr_data | input | ADDR_W | Direct user pointer write data |
| sup_mode | output | 1 | Current mode bit |
| sr_q | output | 16 | Current status word |
| saved_s | output | 1 | Mode bit saved by the last exception entry |
| a7_rdata | output | ADDR_W | Mode-selected stack pointer |
| usp_rdata | output | ADDR_W | User stack pointer |
| priv_viol | output | 1 | Privilege violation strobe |
| exc_taken | output | 1 | Exception entry applied this cycle |
| bus_super | output | 1 | Bus reference class: 1 supervisor, 0 user |

## Verification
The bench checks that a write which clears the mode bit redirects the stack alias only from the following cycle. A unit that switched early would send that cycle's stack write to the wrong pointer. It checks that extended classes are restricted only when the enable is set. A decoder wired the other way would fault ordinary user code or let control moves through. It also issues violating instructions that carry stack, user-pointer and status writes, along with an exception request that coincides with instruction writes. A design that leaked commits would corrupt the pointers or let user code raise its own privilege. A design with a badly timed saved-mode capture would record supervisor for a fault taken from user mode.

// File: rtl/priv_pkg.sv
package priv_pkg;

    localparam int SR_W  = 16;
    localparam int S_BIT = 13;
    localparam int CCR_W = 8;
    localparam int CLS_W = 4;

    localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << S_BIT;

    typedef enum logic [CLS_W-1:0] {
        IC_PLAIN     = 4'd0,
        IC_HALT      = 4'd1,
        IC_EXT_RESET = 4'd2,
        IC_SR_WRITE  = 4'd3,
        IC_USP_MOVE  = 4'd4,
        IC_SR_READ   = 4'd5,
        IC_CTRL_MOVE = 4'd6,
        IC_ALT_MOVE  = 4'd7
    } iclass_e;

    typedef enum logic {
        BANK_USER  = 1'b0,
        BANK_SUPER = 1'b1
    } bank_e;

    typedef struct packed {
        logic            en;
        logic            full;
        logic [SR_W-1:0] data;
    } sr_wr_t;

    function automatic logic base_restricted(input logic [CLS_W-1:0] c);
        return (c == IC_HALT) || (c == IC_EXT_RESET) ||
               (c == IC_SR_WRITE) || (c == IC_USP_MOVE);
    endfunction

    function automatic logic ext_restricted(input logic [CLS_W-1:0] c);
        return (c == IC_SR_READ) || (c == IC_CTRL_MOVE) || (c == IC_ALT_MOVE);
    endfunction

endpackage

// File: rtl/priv_check.sv
module priv_check
    import priv_pkg::*;
(
    input  logic             instr_valid,
    input  logic [CLS_W-1:0] instr_class,
    input  logic             ext_priv_en,
    input  sr_wr_t           sr_wr,
    input  logic             s_bit,
    input  logic             enter,
    output logic             viol,
    output logic             commit
);
    logic restricted;
    logic live;

    always_comb begin
        restricted = base_restricted(instr_class) ||
                     (ext_priv_en && ext_restricted(instr_class)) ||
                     (sr_wr.en && sr_wr.full);
        live       = instr_valid && !enter;
        viol       = live && !s_bit && restricted;
        commit     = live && !viol;
    end

    always_comb begin
        if (viol) assert_no_commit_on_viol_R8: assert (!commit);
    end

endmodule

// File: rtl/priv_mode_reg.sv
module priv_mode_reg
    import priv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enter,
    input  logic            commit,
    input  sr_wr_t          sr_wr,
    output logic [SR_W-1:0] sr_q,
    output logic            saved_s
);
    logic [SR_W-1:0] sr_r;
    logic            sav_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_r  <= SR_RESET;
            sav_r <= 1'b0;
        end else if (enter) begin
            sav_r       <= sr_r[S_BIT];
            sr_r[S_BIT] <= 1'b1;
        end else if (commit && sr_wr.en) begin
            if (!sr_wr.full)
                sr_r[CCR_W-1:0] <= sr_wr.data[CCR_W-1:0];
            else if (sr_r[S_BIT])
                sr_r <= sr_wr.data;
        end
    end

    assign sr_q    = sr_r;
    assign saved_s = sav_r;

    assert_entry_sets_s_R9: assert property (@(posedge clk) disable iff (rst)
        enter |=> sr_q[S_BIT]);

    assert_entry_saves_s_R9: assert property (@(posedge clk) disable iff (rst)
        enter |=> saved_s == $past(sr_q[S_BIT]));

    assert_user_cannot_raise_R7: assert property (@(posedge clk) disable iff (rst)
        (!sr_q[S_BIT] && !enter) |=> !sr_q[S_BIT]);

endmodule

// File: rtl/stack_bank.sv
module stack_bank
    import priv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_super,
    input  logic              a7_we,
    input  logic [ADDR_W-1:0] a7_wd,
    input  logic              usp_we,
    input  logic [ADDR_W-1:0] usp_wd,
    output logic [ADDR_W-1:0] a7_rd,
    output logic [ADDR_W-1:0] usp_rd
);
    localparam int NBANK = 2;

    logic [ADDR_W-1:0] ptr_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam bank_e ME = bank_e'(b);
        logic              we;
        logic [ADDR_W-1:0] wd;

        always_comb begin
            if (ME == BANK_SUPER) begin
                we = a7_we && sel_super;
                wd = a7_wd;
            end else begin
                we = (a7_we && !sel_super) || (usp_we && sel_super);
                wd = (a7_we && !sel_super) ? a7_wd : usp_wd;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)     ptr_q[b] <= '0;
            else if (we) ptr_q[b] <= wd;
        end
    end

    assign a7_rd  = sel_super ? ptr_q[BANK_SUPER] : ptr_q[BANK_USER];
    assign usp_rd = ptr_q[BANK_USER];

    assert_ssp_kept_in_user_R3: assert property (@(posedge clk) disable iff (rst)
        !sel_super |=> ptr_q[BANK_SUPER] == $past(ptr_q[BANK_SUPER]));

    assert_usp_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!a7_we && !usp_we) |=> $stable(usp_rd));

endmodule

// File: rtl/priv_stack_unit.sv
module priv_stack_unit
    import priv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [3:0]        instr_class,
    input  logic              ext_priv_en,
    input  logic              sr_wr_en,
    input  logic              sr_wr_full,
    input  logic [15:0]       sr_wr_data,
    input  logic              exc_entry,
    input  logic              a7_wr_en,
    input  logic [ADDR_W-1:0] a7_wr_data,
    input  logic              usp_wr_en,
    input  logic [ADDR_W-1:0] usp_wr_data,
    output logic              sup_mode,
    output logic [15:0]       sr_q,
    output logic              saved_s,
    output logic [ADDR_W-1:0] a7_rdata,
    output logic [ADDR_W-1:0] usp_rdata,
    output logic              priv_viol,
    output logic              exc_taken,
    output logic              bus_super
);
    sr_wr_t          sr_wr;
    logic [SR_W-1:0] sr_cur;
    logic            s_now;
    logic            viol;
    logic            commit;
    logic            viol_q;
    logic            enter;

    assign sr_wr = '{en: sr_wr_en, full: sr_wr_full, data: sr_wr_data};
    assign s_now = sr_cur[S_BIT];
    assign enter = exc_entry || viol_q;

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= viol;
    end

    priv_check u_check (
        .instr_valid (instr_valid),
        .instr_class (instr_class),
        .ext_priv_en (ext_priv_en),
        .sr_wr       (sr_wr),
        .s_bit       (s_now),
        .enter       (enter),
        .viol        (viol),
        .commit      (commit)
    );

    priv_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .enter   (enter),
        .commit  (commit),
        .sr_wr   (sr_wr),
        .sr_q    (sr_cur),
        .saved_s (saved_s)
    );

    stack_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .sel_super (s_now),
        .a7_we     (a7_wr_en && commit),
        .a7_wd     (a7_wr_data),
        .usp_we    (usp_wr_en && commit),
        .usp_wd    (usp_wr_data),
        .a7_rd     (a7_rdata),
        .usp_rd    (usp_rdata)
    );

    assign sr_q      = sr_cur;
    assign sup_mode  = s_now;
    assign bus_super = s_now;
    assign priv_viol = viol;
    assign exc_taken = enter;

    assert_viol_enters_R9: assert property (@(posedge clk) disable iff (rst)
        priv_viol |=> exc_taken);

    assert_viol_keeps_ccr_R8: assert property (@(posedge clk) disable iff (rst)
        priv_viol |=> sr_q[CCR_W-1:0] == $past(sr_q[CCR_W-1:0]));

    assert_viol_keeps_usp_R8: assert property (@(posedge clk) disable iff (rst)
        priv_viol |=> $stable(usp_rdata));

    assert_viol_only_user_R4: assert property (@(posedge clk) disable iff (rst)
        priv_viol |-> !bus_super);

endmodule

// File: tb/priv_stack_unit_tb.sv
module priv_stack_unit_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [3:0]    instr_class = '0;
    logic          ext_priv_en = 1'b0;
    logic          sr_wr_en = 1'b0;
    logic          sr_wr_full = 1'b0;
    logic [15:0]   sr_wr_data = '0;
    logic          exc_entry = 1'b0;
    logic          a7_wr_en = 1'b0;
    logic [AW-1:0] a7_wr_data = '0;
    logic          usp_wr_en = 1'b0;
    logic [AW-1:0] usp_wr_data = '0;
    logic          sup_mode, saved_s, priv_viol, exc_taken, bus_super;
    logic [15:0]   sr_q;
    logic [AW-1:0] a7_rdata, usp_rdata;

    always #4 clk = ~clk;

    priv_stack_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
        .ext_priv_en(ext_priv_en), .sr_wr_en(sr_wr_en), .sr_wr_full(sr_wr_full),
        .sr_wr_data(sr_wr_data), .exc_entry(exc_entry), .a7_wr_en(a7_wr_en),
        .a7_wr_data(a7_wr_data), .usp_wr_en(usp_wr_en), .usp_wr_data(usp_wr_data),
        .sup_mode(sup_mode), .sr_q(sr_q), .saved_s(saved_s), .a7_rdata(a7_rdata),
        .usp_rdata(usp_rdata), .priv_viol(priv_viol), .exc_taken(exc_taken),
        .bus_super(bus_super)
    );

    typedef struct {
        string         tag;
        logic [15:0]   sr;
        logic          sav;
        logic [AW-1:0] a7;
        logic [AW-1:0] usp;
        logic          viol;
        logic          exc;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // reference state, from the requirements
    logic [15:0]   m_sr = 16'h2000;
    logic          m_sav = 1'b0;
    logic [AW-1:0] m_ssp = '0;
    logic [AW-1:0] m_usp = '0;
    logic          m_vq = 1'b0;

    task automatic cmp(string tag, string f, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
        end
    endtask

    // monitor: pops expected items and compares the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "sr_q", AW'(sr_q), AW'(e.sr));
                cmp(e.tag, "sup_mode", AW'(sup_mode), AW'(e.sr[13]));
                cmp(e.tag, "bus_super", AW'(bus_super), AW'(e.sr[13]));
                cmp(e.tag, "saved_s", AW'(saved_s), AW'(e.sav));
                cmp(e.tag, "a7_rdata", a7_rdata, e.a7);
                cmp(e.tag, "usp_rdata", usp_rdata, e.usp);
                cmp(e.tag, "priv_viol", AW'(priv_viol), AW'(e.viol));
                cmp(e.tag, "exc_taken", AW'(exc_taken), AW'(e.exc));
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(string tag, bit iv, int cls, bit ext,
                        bit srw, bit srf, logic [15:0] srd, bit exc,
                        bit a7w, logic [AW-1:0] a7d, bit uw, logic [AW-1:0] ud);
        bit   s, ent, pr, vi, cm;
        exp_t e;
        @(negedge clk);
        instr_valid = iv; instr_class = 4'(cls); ext_priv_en = ext;
        sr_wr_en = srw; sr_wr_full = srf; sr_wr_data = srd; exc_entry = exc;
        a7_wr_en = a7w; a7_wr_data = a7d; usp_wr_en = uw; usp_wr_data = ud;
        s   = m_sr[13];
        ent = exc || m_vq;
        pr  = (cls >= 1 && cls <= 4) || (ext && cls >= 5 && cls <= 7) || (srw && srf);
        vi  = iv && !ent && !s && pr;
        cm  = iv && !ent && !vi;
        e.tag = tag; e.sr = m_sr; e.sav = m_sav; e.a7 = s ? m_ssp : m_usp;
        e.usp = m_usp; e.viol = vi; e.exc = ent;
        q.push_back(e);
        m_vq = vi;
        if (ent) begin
            m_sav = s;
            m_sr[13] = 1'b1;
        end else if (cm) begin
            if (srw) begin
                if (!srf) m_sr[7:0] = srd[7:0];
                else if (s) m_sr = srd;
            end
            if (a7w) begin
                if (s) m_ssp = a7d; else m_usp = a7d;
            end
            if (uw && s) m_usp = ud;
        end
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, '0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        // supervisor alias and direct user pointer access
        step("R3 sup a7 write", 1, 0, 0, 0, 0, '0, 0, 1, 32'h0000_1000, 0, '0);
        step("R11 sup usp write", 1, 4, 0, 0, 0, '0, 0, 0, '0, 1, 32'h0000_2000);
        idle("R3 R11 readback");
        step("R4 halt in sup", 1, 1, 0, 0, 0, '0, 0, 0, '0, 0, '0);
        step("R5 ctrl move in sup ext", 1, 6, 1, 0, 0, '0, 0, 0, '0, 0, '0);
        step("R6 sup full write", 1, 3, 0, 1, 1, 16'h2715, 0, 0, '0, 0, '0);
        // clear S: a7 write in the same cycle still hits supervisor pointer
        step("R10 clear S", 1, 3, 0, 1, 1, 16'h0015, 0, 1, 32'h0000_1100, 0, '0);
        idle("R10 alias switched");
        step("R3 user a7 write", 1, 0, 0, 0, 0, '0, 0, 1, 32'h0000_3000, 0, '0);
        step("R11 user usp_wr ignored", 1, 0, 0, 0, 0, '0, 0, 0, '0, 1, 32'hDEAD_0000);
        step("R5 sr read no ext", 1, 5, 0, 0, 0, '0, 0, 0, '0, 0, '0);
        step("R5 class 9 ext", 1, 9, 1, 0, 0, '0, 0, 0, '0, 0, '0);
        step("R7 user ccr write", 1, 0, 0, 1, 0, 16'hFFAA, 0, 0, '0, 0, '0);
        step("R5 ctrl move ext viol", 1, 6, 1, 0, 0, '0, 0, 1, 32'h0000_4444, 0, '0);
        step("R9 entry after viol", 1, 0, 0, 1, 0, 16'h0001, 0, 1, 32'h5555, 0, '0);
        idle("R9 R10 back in sup");
        step("R6 back to user", 1, 3, 0, 1, 1, 16'h0003, 0, 0, '0, 0, '0);
        step("R6 user full write viol", 1, 3, 0, 1, 1, 16'h2000, 0, 0, '0, 0, '0);
        idle("R9 R7 entry");
        step("R6 user again", 1, 3, 0, 1, 1, 16'h0000, 0, 0, '0, 0, '0);
        step("R8 halt with writes", 1, 1, 0, 0, 0, '0, 0, 1, 32'h7777, 1, 32'h8888);
        idle("R8 R9 entry");
        step("R4 usp move sup", 1, 4, 0, 0, 0, '0, 0, 0, '0, 1, 32'h0000_6000);
        step("R10 user once more", 1, 3, 0, 1, 1, 16'h0000, 0, 0, '0, 0, '0);
        step("R4 ext reset user", 1, 2, 0, 0, 0, '0, 0, 0, '0, 0, '0);
        idle("R9 entry again");
        step("R10 to user", 1, 3, 0, 1, 1, 16'h0000, 0, 0, '0, 0, '0);
        step("R9 exc with writes", 1, 0, 0, 1, 0, 16'h00FF, 1, 1, 32'h9999, 0, '0);
        step("R9 exc in sup", 0, 0, 0, 0, 0, '0, 1, 0, '0, 0, '0);
        step("R2 plain sup", 1, 0, 0, 0, 0, '0, 0, 0, '0, 0, '0);
        idle("R1 final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule